// File: doc/BRIEF.md
# Display Window CRC Monitor

The monitor sits beside a pixel stream (pixel clock, frame sync, line sync, data-enable and pixel data) and checks that selected regions of the picture carry the expected content. Up to sixteen rectangular windows can be placed on the frame. Each window owns a channel that runs a CRC-32 over the pixels falling inside it. At every frame boundary, each active channel publishes its result and compares it against a stored golden value. A mismatch raises a per-channel error flag. Every completed frame raises a single frame-done flag.

The pixel clock is not used as a clock. It is sampled in the system clock domain, and a selectable edge of it qualifies each pixel. Pixel coordinates come from the syncs. A frame-sync strobe resets column and row to zero. A line-sync strobe returns the column to zero, and it advances the row when the line just ended carried data. Each data-enable strobe is one pixel at the current coordinate and then advances the column. Software drives a single-cycle register port. Through it, software places the windows, enables or freezes channels, loads golden values, masks interrupt causes, and acknowledges flags.

Top module: `gwm_top`

Register map (word addresses): 0x00 global control (bit0 run, bit1 sample on falling pixel-clock edge); 0x01 interrupt mask (bit0 masks the error group, bit1 masks frame-done, 1 = masked); 0x02 status (bits 15:0 channel error, bit16 frame-done, write 1 to clear); 0x03 mask lock (write bit0 = 1). Channel n owns 0x40+4n: +0 control (bit0 enable, bit1 freeze), +1 window top-left and +2 window bottom-right (column in bits 12:0, row in bits 27:16), +3 golden CRC. The computed CRC of channel n reads at 0x80+n.

## Requirements
- R1: After reset the interrupt mask reads 0x3, status reads 0, irq is low, and every channel control register reads 0.
- R2: For an active channel (run = 1 and channel enable = 1), the CRC read at 0x80+n after a frame ends is the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones, output inverted) of its window's pixels in raster order. Each 24-bit pixel is fed least significant byte first.
- R3: A disabled channel neither accumulates pixels nor updates its readable CRC at frame end.
- R4: Window bounds are inclusive on all four sides: single-pixel, single-row and single-column windows, including the bottom-right corner of the frame, are checked correctly.
- R5: At the end of each frame, an active channel whose CRC differs from its golden value sets its status bit n. A matching channel leaves bit n clear.
- R6: Each frame end while run = 1 sets status bit 16.
- R7: Writing 1 to a status bit clears it. Bits written with 0 keep their value.
- R8: irq is high exactly when an error bit is set with mask bit0 = 0, or bit 16 is set with mask bit1 = 0.
- R9: After bit0 = 1 is written to 0x03, writes to the mask have no effect until reset.
- R10: Once a channel's freeze bit is set, writes to its control and window registers are ignored. Its golden value stays writable.
- R11: Window writes are ignored while the channel is enabled. The edge-select bit can only change while run = 0.
- R12: With the edge-select bit set, pixels are taken on falling pixel-clock edges instead of rising ones.
- R13: Channel indices above 15 (addresses 0x90 to 0xFF) read 0 and writing them changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Pixel clock, sampled as data |
| pix_vs | input | 1 | Frame sync, qualified by the pixel edge |
| pix_hs | input | 1 | Line sync, qualified by the pixel edge |
| pix_de | input | 1 | Pixel data valid |
| pix_data | input | PIX_W | Pixel value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach from the ports is the edge-select bit taking effect. The sampler must take the pixel on the chosen edge and never on the opposite one, yet a stream whose data is stable across both edges cannot tell them apart. The stimulus therefore drives valid pixels only around the active edge, and it drives junk data with data-enable high around the other edge. A sampler that uses the wrong edge then folds junk into the CRC. Changing the edge select also needs run to be cleared first and the pixel clock parked at the new idle level, so that the change produces no spurious strobe.

// File: rtl/gwm_pkg.sv
package gwm_pkg;

    localparam int COL_W    = 13;
    localparam int ROW_W    = 12;
    localparam int CRC_W    = 32;
    localparam int AW       = 8;
    localparam int DW       = 32;
    localparam int DONE_BIT = 16;
    localparam int STS_W    = DONE_BIT + 1;
    localparam int ROW_LSB  = 16;

    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_PRESET    = 32'hFFFF_FFFF;

    localparam logic [AW-1:0] A_GCTRL = 8'h00;
    localparam logic [AW-1:0] A_IMASK = 8'h01;
    localparam logic [AW-1:0] A_ISTAT = 8'h02;
    localparam logic [AW-1:0] A_ILOCK = 8'h03;

    typedef struct packed {
        logic [COL_W-1:0] c0;
        logic [ROW_W-1:0] r0;
        logic [COL_W-1:0] c1;
        logic [ROW_W-1:0] r1;
    } win_t;

    typedef enum logic [1:0] {
        F_CTRL  = 2'd0,
        F_START = 2'd1,
        F_END   = 2'd2,
        F_GOLD  = 2'd3
    } chfield_e;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } xy_t;

    function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c, input logic d);
        logic fb;
        fb = c[0] ^ d;
        return {1'b0, c[CRC_W-1:1]} ^ (fb ? CRC_POLY_REFL : '0);
    endfunction

    function automatic logic [DW-1:0] pack_xy(input logic [COL_W-1:0] c, input logic [ROW_W-1:0] r);
        logic [DW-1:0] v;
        v = '0;
        v[COL_W-1:0] = c;
        v[ROW_LSB +: ROW_W] = r;
        return v;
    endfunction

    function automatic logic in_win(input win_t w, input xy_t p);
        return (p.col >= w.c0) && (p.col <= w.c1) && (p.row >= w.r0) && (p.row <= w.r1);
    endfunction

endpackage

// File: rtl/gwm_edge.sv
module gwm_edge (
    input  logic clk,
    input  logic rst,
    input  logic pclk,
    input  logic fall_sel,
    output logic stb
);
    logic pclk_q;

    always_ff @(posedge clk) begin
        if (rst) pclk_q <= 1'b0;
        else     pclk_q <= pclk;
    end

    // strobe in the cycle after the chosen transition of the pixel clock
    assign stb = (pclk != pclk_q) && (pclk == !fall_sel);
endmodule

// File: rtl/gwm_raster.sv
module gwm_raster
    import gwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic vs,
    input  logic hs,
    input  logic de,
    output xy_t  pos,
    output logic pix_ok,
    output logic frame_tick,
    output logic frame_close
);
    logic open_q;
    logic line_has_q;
    xy_t  pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q     <= 1'b0;
            line_has_q <= 1'b0;
            pos_q      <= '0;
        end else if (stb) begin
            if (vs) begin
                pos_q      <= '0;
                open_q     <= 1'b1;
                line_has_q <= 1'b0;
            end else if (hs) begin
                pos_q.col  <= '0;
                if (line_has_q) pos_q.row <= pos_q.row + 1'b1;
                line_has_q <= 1'b0;
            end else if (de) begin
                pos_q.col  <= pos_q.col + 1'b1;
                line_has_q <= 1'b1;
            end
        end
    end

    assign pos         = pos_q;
    assign pix_ok      = stb && de && !vs && !hs && open_q;
    assign frame_tick  = stb && vs;
    assign frame_close = frame_tick && open_q;
endmodule

// File: rtl/gwm_chan.sv
module gwm_chan
    import gwm_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  win_t             win,
    input  logic [CRC_W-1:0] gold,
    input  logic             pix_ok,
    input  xy_t              pos,
    input  logic [PIX_W-1:0] data,
    input  logic             frame_tick,
    input  logic             frame_close,
    output logic [CRC_W-1:0] calc,
    output logic             mism
);
    logic [CRC_W-1:0] run_q;
    logic [CRC_W-1:0] calc_q;
    logic [CRC_W-1:0] next_crc;
    logic             hit;

    always_comb begin
        next_crc = run_q;
        for (int i = 0; i < PIX_W; i++) next_crc = crc_bit(next_crc, data[i]);
    end

    assign hit = active && pix_ok && in_win(win, pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= CRC_PRESET;
            calc_q <= '0;
        end else begin
            if (frame_tick)  run_q <= CRC_PRESET;
            else if (hit)    run_q <= next_crc;
            if (frame_close && active) calc_q <= ~run_q;
        end
    end

    assign calc = calc_q;
    assign mism = frame_close && active && ((~run_q) != gold);
endmodule

// File: rtl/gwm_top.sv
module gwm_top
    import gwm_pkg::*;
#(
    parameter int N_CH  = 16,
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_clk,
    input  logic             pix_vs,
    input  logic             pix_hs,
    input  logic             pix_de,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq
);
    localparam logic [4:0] N_CH_L = 5'(N_CH);

    logic               run_q, inv_q, lock_q;
    logic [1:0]         mask_q;
    logic [STS_W-1:0]   sts_q;
    logic [N_CH-1:0]    en_q, frz_q;
    win_t [N_CH-1:0]    win_q;
    logic [CRC_W-1:0]   gold_q [N_CH];
    logic [CRC_W-1:0]   calc   [N_CH];
    logic [N_CH-1:0]    mism;

    logic      stb, pix_ok, frame_tick, frame_close;
    xy_t       pos;
    logic      is_ch, ch_ok, is_crc, crc_ok;
    logic [3:0] ch_idx, crc_idx;
    chfield_e  fld;
    logic [STS_W-1:0] sts_set, sts_clr;

    gwm_edge u_edge (
        .clk(clk), .rst(rst), .pclk(pix_clk), .fall_sel(inv_q), .stb(stb)
    );

    gwm_raster u_raster (
        .clk(clk), .rst(rst), .stb(stb), .vs(pix_vs), .hs(pix_hs), .de(pix_de),
        .pos(pos), .pix_ok(pix_ok), .frame_tick(frame_tick), .frame_close(frame_close)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        gwm_chan #(.PIX_W(PIX_W)) u_chan (
            .clk(clk), .rst(rst), .active(run_q && en_q[g]),
            .win(win_q[g]), .gold(gold_q[g]),
            .pix_ok(pix_ok), .pos(pos), .data(pix_data),
            .frame_tick(frame_tick), .frame_close(frame_close),
            .calc(calc[g]), .mism(mism[g])
        );
    end

    // address decode
    assign is_ch   = (reg_addr[7:6] == 2'b01);
    assign ch_idx  = reg_addr[5:2];
    assign fld     = chfield_e'(reg_addr[1:0]);
    assign ch_ok   = is_ch && ({1'b0, ch_idx} < N_CH_L);
    assign is_crc  = (reg_addr[7:4] == 4'h8);
    assign crc_idx = reg_addr[3:0];
    assign crc_ok  = is_crc && ({1'b0, crc_idx} < N_CH_L);

    always_comb begin
        sts_set = '0;
        sts_set[N_CH-1:0] = mism;
        sts_set[DONE_BIT] = frame_close && run_q;
        sts_clr = (reg_wr && reg_addr == A_ISTAT) ? reg_wdata[STS_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            inv_q  <= 1'b0;
            lock_q <= 1'b0;
            mask_q <= 2'b11;
            sts_q  <= '0;
            en_q   <= '0;
            frz_q  <= '0;
            win_q  <= '0;
            for (int i = 0; i < N_CH; i++) gold_q[i] <= '0;
        end else begin
            sts_q <= (sts_q & ~sts_clr) | sts_set;
            if (reg_wr) begin
                if (reg_addr == A_GCTRL) begin
                    run_q <= reg_wdata[0];
                    if (!run_q) inv_q <= reg_wdata[1];
                end
                if (reg_addr == A_IMASK && !lock_q) mask_q <= reg_wdata[1:0];
                if (reg_addr == A_ILOCK && reg_wdata[0]) lock_q <= 1'b1;
                for (int i = 0; i < N_CH; i++) begin
                    if (ch_ok && ch_idx == 4'(i)) begin
                        case (fld)
                            F_CTRL: if (!frz_q[i]) begin
                                en_q[i]  <= reg_wdata[0];
                                frz_q[i] <= reg_wdata[1];
                            end
                            F_START: if (!frz_q[i] && !en_q[i]) begin
                                win_q[i].c0 <= reg_wdata[COL_W-1:0];
                                win_q[i].r0 <= reg_wdata[ROW_LSB +: ROW_W];
                            end
                            F_END: if (!frz_q[i] && !en_q[i]) begin
                                win_q[i].c1 <= reg_wdata[COL_W-1:0];
                                win_q[i].r1 <= reg_wdata[ROW_LSB +: ROW_W];
                            end
                            default: gold_q[i] <= reg_wdata;
                        endcase
                    end
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (ch_ok) begin
            case (fld)
                F_CTRL:  reg_rdata[1:0] = {frz_q[ch_idx], en_q[ch_idx]};
                F_START: reg_rdata = pack_xy(win_q[ch_idx].c0, win_q[ch_idx].r0);
                F_END:   reg_rdata = pack_xy(win_q[ch_idx].c1, win_q[ch_idx].r1);
                default: reg_rdata = gold_q[ch_idx];
            endcase
        end else if (crc_ok) begin
            reg_rdata = calc[crc_idx];
        end else begin
            case (reg_addr)
                A_GCTRL: reg_rdata[1:0] = {inv_q, run_q};
                A_IMASK: reg_rdata[1:0] = mask_q;
                A_ISTAT: reg_rdata[STS_W-1:0] = sts_q;
                A_ILOCK: reg_rdata[0] = lock_q;
                default: reg_rdata = '0;
            endcase
        end
    end

    assign irq = ((|sts_q[N_CH-1:0]) && !mask_q[0]) || (sts_q[DONE_BIT] && !mask_q[1]);
endmodule

// File: rtl/gwm_checker.sv
module gwm_checker
    import gwm_pkg::*;
#(
    parameter int N_CH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             inv,
    input logic             lock,
    input logic [1:0]       mask,
    input logic [STS_W-1:0] sts,
    input logic             fclose,
    input logic             irq,
    input logic [N_CH-1:0]  en,
    input logic [N_CH-1:0]  frz,
    input win_t [N_CH-1:0]  win
);
    assert_mask_locked_R9: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(mask));

    assert_status_rise_at_frame_R5: assert property (@(posedge clk) disable iff (rst)
        !fclose |=> ((sts & ~$past(sts)) == '0));

    assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (sts != '0));

    assert_freeze_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (frz != '0) |=> ((frz & $past(frz)) == $past(frz)));

    assert_edge_sel_hold_R11: assert property (@(posedge clk) disable iff (rst)
        run |=> $stable(inv));

    for (genvar g = 0; g < N_CH; g++) begin : g_win
        assert_win_hold_enabled_R11: assert property (@(posedge clk) disable iff (rst)
            en[g] |=> $stable(win[g]));
        assert_win_hold_frozen_R10: assert property (@(posedge clk) disable iff (rst)
            frz[g] |=> $stable(win[g]));
    end
endmodule

bind gwm_top gwm_checker #(.N_CH(N_CH)) i_gwm_checker (
    .clk(clk), .rst(rst), .run(run_q), .inv(inv_q), .lock(lock_q), .mask(mask_q),
    .sts(sts_q), .fclose(frame_close), .irq(irq), .en(en_q), .frz(frz_q), .win(win_q)
);

// File: tb/test_gwm_top.sv
module test_gwm_top;
    localparam int FW = 6;
    localparam int FH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_clk = 1'b0, pix_vs = 1'b0, pix_hs = 1'b0, pix_de = 1'b0;
    logic [23:0] pix_data = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  inv_mode = 1'b0;
    bit  opened = 1'b0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    gwm_top i_gwm_top (
        .clk(clk), .rst(rst), .pix_clk(pix_clk), .pix_vs(pix_vs), .pix_hs(pix_hs),
        .pix_de(pix_de), .pix_data(pix_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct packed { int ch; int c0; int r0; int c1; int r1; int seed; } vec_t;
    localparam vec_t TBL [5] = '{
        '{0,  0, 0, 5, 3, 11},
        '{3,  1, 1, 3, 2, 22},
        '{15, 5, 3, 5, 3, 33},
        '{7,  0, 2, 5, 2, 44},
        '{9,  2, 0, 2, 3, 55}
    };

    function automatic logic [23:0] pixval(int seed, int c, int r);
        logic [31:0] v;
        v = (32'(seed) * 32'h9E37_79B1) ^ (32'(c) << 8) ^ (32'(r) << 16) ^ 32'(c * r * 7 + 1);
        return v[23:0];
    endfunction

    function automatic logic [31:0] crc_px(logic [31:0] c, logic [23:0] p);
        for (int b = 0; b < 3; b++) begin
            c ^= {24'h0, p[8*b +: 8]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return c;
    endfunction

    function automatic logic [31:0] exp_crc(int seed, int c0, int r0, int c1, int r1);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int r = 0; r < FH; r++)
            for (int x = 0; x < FW; x++)
                if (x >= c0 && x <= c1 && r >= r0 && r <= r1) c = crc_px(c, pixval(seed, x, r));
        return ~c;
    endfunction

    function automatic logic [31:0] xy(int c, int r);
        return (32'(r) << 16) | 32'(c);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic irq_now(output logic v);
        @(negedge clk);
        #1 v = irq;
    endtask

    // valid values around the active edge, junk with de high around the other one
    task automatic pix(logic vs, logic hs, logic de, logic [23:0] d);
        logic act;
        act = inv_mode ? 1'b0 : 1'b1;
        pix_vs = vs; pix_hs = hs; pix_de = de; pix_data = d;
        repeat (2) @(negedge clk);
        pix_clk = act;
        repeat (2) @(negedge clk);
        pix_vs = 1'b0; pix_hs = 1'b0; pix_de = 1'b1; pix_data = d ^ 24'hA5C3_1E;
        @(negedge clk);
        pix_clk = ~act;
        repeat (2) @(negedge clk);
        pix_de = 1'b0;
    endtask

    task automatic run_frame(int seed);
        if (!opened) begin
            pix(1'b1, 1'b0, 1'b0, '0);
            opened = 1'b1;
        end
        for (int r = 0; r < FH; r++) begin
            for (int c = 0; c < FW; c++) pix(1'b0, 1'b0, 1'b1, pixval(seed, c, r));
            pix(1'b0, 1'b1, 1'b0, '0);
        end
        pix(1'b1, 1'b0, 1'b0, '0);
    endtask

    task automatic cfg_ch(int ch, int c0, int r0, int c1, int r1, logic [31:0] gold);
        logic [7:0] b;
        b = 8'(8'h40 + 4 * ch);
        wr(b, 32'h0);
        wr(b + 8'd1, xy(c0, r0));
        wr(b + 8'd2, xy(c1, r1));
        wr(b + 8'd3, gold);
        wr(b, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, e, e0;
        logic        q;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h01, v); check("R1 mask", v, 32'h3);
        rd(8'h02, v); check("R1 status", v, 32'h0);
        irq_now(q);   check("R1 irq", {31'b0, q}, 32'h0);
        rd(8'h40, v); check("R1 ch0 ctrl", v, 32'h0);

        wr(8'h00, 32'h1);
        e0 = '0;
        // R2 R4 R5 R6: table of windows, odd entries carry a wrong golden value
        for (int i = 0; i < 5; i++) begin
            vec_t t;
            bit   bad;
            t   = TBL[i];
            bad = (i % 2) == 1;
            e   = exp_crc(t.seed, t.c0, t.r0, t.c1, t.r1);
            if (i == 0) e0 = e;
            cfg_ch(t.ch, t.c0, t.r0, t.c1, t.r1, e ^ {31'b0, bad});
            wr(8'h02, 32'h1_FFFF);
            run_frame(t.seed);
            rd(8'(8'h80 + t.ch), v); check("R2 R4 window crc", v, e);
            rd(8'h02, v);
            check("R5 R6 status after frame", v, (32'h1 << 16) | (32'(bad) << t.ch));
            if (i == 1) begin
                wr(8'h02, 32'h1_0000);
                rd(8'h02, v); check("R7 w1c keeps other bits", v, 32'h1 << t.ch);
            end
            wr(8'(8'h40 + 4 * t.ch), 32'h0);
        end

        // R3 disabled channel keeps last result
        wr(8'h02, 32'h1_FFFF);
        run_frame(99);
        rd(8'h80, v); check("R3 disabled ch0 crc unchanged", v, e0);
        rd(8'h02, v); check("R3 no error from disabled channels", v, 32'h1_0000);

        // R8 interrupt masking
        cfg_ch(0, 0, 0, 5, 3, 32'h0);
        wr(8'h02, 32'h1_FFFF);
        run_frame(77);
        rd(8'h02, v); check("R5 mismatch flags ch0", v, 32'h1_0001);
        irq_now(q); check("R8 all masked", {31'b0, q}, 32'h0);
        wr(8'h01, 32'h2);
        irq_now(q); check("R8 error unmasked", {31'b0, q}, 32'h1);
        wr(8'h01, 32'h1);
        irq_now(q); check("R8 done unmasked", {31'b0, q}, 32'h1);
        wr(8'h02, 32'h1_0000);
        irq_now(q); check("R8 done cleared", {31'b0, q}, 32'h0);
        wr(8'h01, 32'h2);
        irq_now(q); check("R8 error still pending", {31'b0, q}, 32'h1);
        wr(8'h02, 32'h1);
        irq_now(q); check("R7 R8 error cleared", {31'b0, q}, 32'h0);
        wr(8'h40, 32'h0);

        // R9 mask lock
        wr(8'h03, 32'h1);
        wr(8'h01, 32'h0);
        rd(8'h01, v); check("R9 mask locked", v, 32'h2);

        // R10 freeze
        wr(8'h49, xy(1, 1));
        wr(8'h48, 32'h2);
        wr(8'h49, xy(4, 3));
        rd(8'h49, v); check("R10 frozen window", v, xy(1, 1));
        wr(8'h48, 32'h1);
        rd(8'h48, v); check("R10 frozen ctrl", v, 32'h2);
        wr(8'h4B, 32'hCAFE_F00D);
        rd(8'h4B, v); check("R10 golden writable", v, 32'hCAFE_F00D);

        // R11 write guards
        wr(8'h54, 32'h1);
        wr(8'h55, xy(2, 2));
        rd(8'h55, v); check("R11 window ignored while enabled", v, 32'h0);
        wr(8'h54, 32'h0);
        wr(8'h55, xy(2, 2));
        rd(8'h55, v); check("R11 window accepted while disabled", v, xy(2, 2));
        wr(8'h00, 32'h3);
        rd(8'h00, v); check("R11 edge select held while running", v, 32'h1);

        // R13 out-of-range channel index
        rd(8'h90, v); check("R13 read idx 16", v, 32'h0);
        wr(8'hA0, 32'hFFFF_FFFF);
        rd(8'hA0, v); check("R13 read idx 32", v, 32'h0);
        rd(8'h00, v); check("R13 global untouched", v, 32'h1);
        rd(8'h40, v); check("R13 ch0 untouched", v, 32'h0);

        // R12 falling-edge sampling
        wr(8'h00, 32'h0);
        pix_vs = 1'b0; pix_hs = 1'b0; pix_de = 1'b0;
        pix_clk = 1'b1;
        repeat (3) @(negedge clk);
        inv_mode = 1'b1;
        wr(8'h00, 32'h3);
        rd(8'h00, v); check("R12 edge select set", v, 32'h3);
        e = exp_crc(88, 0, 0, 5, 3);
        cfg_ch(0, 0, 0, 5, 3, e);
        wr(8'h02, 32'h1_FFFF);
        run_frame(88);
        rd(8'h80, v); check("R12 crc on falling edge", v, e);
        rd(8'h02, v); check("R12 no mismatch", v, 32'h1_0000);

        // R9 lock lasts only until reset, R1 again
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        rd(8'h01, v); check("R1 mask after reset", v, 32'h3);
        wr(8'h01, 32'h0);
        rd(8'h01, v); check("R9 mask writable after reset", v, 32'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule